// File: doc/BRIEF.md
# I/O Port Window Decoder with Remote DMA Data Port

This block answers a 32-byte window on an 8/16-bit I/O bus. The window's upper address bits are set by a base input. The lower half of the window is a bank of byte-wide control registers. The next eight offsets form a 16-bit data port, and the last eight form a reset port. The host cannot address the internal memory directly. It reaches that memory only through remote DMA. Software loads a start address and a byte count, issues a read or write command, and then moves one 16-bit word per data port access.

The internal memory space is 64K bytes and is only partly decoded. Address bit 14 chooses between a small identity PROM and a buffer RAM, and bit 15 is ignored, so the map repeats in its upper half. The PROM holds a six-byte station address and a signature word, and it mirrors through its whole region. The buffer RAM is word-wide, and its depth is a parameter; the full-size part uses 8K words.

Memory reads take a set number of cycles. During a remote read, the block fetches the next word ahead of the host. If the host reads the data port before that word has arrived, the block drops channel-ready and holds the cycle until the word is present.

Top module: `ioport_rdma`

## Requirements
- R1: An access is decoded only when io_addr bits [IO_AW-1:5] equal cfg_base bits [IO_AW-1:5]. Any other access has no effect on state and reads back 0000h.
- R2: Register offsets in the window: 00h is start address low, 01h is start address high, 02h is byte count low and 03h is byte count high. These four read back their live values. Offset 04h reads done in bit 0. Offset 05h is the command register: writing bit 0 starts a read and writing bit 1 starts a write; it reads back bit 0 = read active and bit 1 = write active. Offsets 06h to 0Fh read 00h. Register reads place the byte on io_rdata[7:0] with io_rdata[15:8] = 00h.
- R3: PROM word k holds {00h, MAC byte k} for k = 0 to 5, where byte k is MAC_ADDR[8k+7:8k]. Words 14 and 15 (byte offsets 1Ch and 1Eh) hold 0057h. All other PROM words read 0000h.
- R4: A memory address with bit 14 = 0 selects the PROM, using address bits [4:1] as the word index. The PROM therefore mirrors through 0000h to 3FFFh and through 8000h to BFFFh.
- R5: A memory address with bit 14 = 1 selects the RAM, using address bits [RAM_AW:1] as the word index. Bit 15 and the bits between are ignored, so C000h to FFFFh aliases 4000h to 7FFFh.
- R6: Each completed data port access (offsets 10h to 17h) during an active DMA adds 2 to the address and subtracts 2 from the count. If the count is 2 or less, it becomes 0 and the DMA ends.
- R7: Done sets when the count reaches 0. A start command clears done. A start command issued with a count of 0 sets done at once and moves no data.
- R8: During a remote read, chrdy is low while the host reads the data port and the prefetched word has not arrived. A read that arrives after the fetch latency completes with no wait.
- R9: Remote DMA writes to the PROM region have no effect.
- R10: Any read or write at offsets 18h to 1Fh pulses soft_reset for one cycle, aborts the active DMA and clears done. It leaves the address and count registers unchanged.
- R11: A data port read when no remote read is active returns 0000h with no wait, and it does not change the address or the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | IO_AW | Window base address; bits [4:0] are ignored |
| io_addr | input | IO_AW | I/O bus address |
| io_rd | input | 1 | Read strobe, held until chrdy is high |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 16 | Write data; registers use bits [7:0] |
| io_rdata | output | 16 | Read data, valid while io_rd is high and chrdy is high |
| chrdy | output | 1 | Channel ready; low inserts a wait state |
| soft_reset | output | 1 | One-cycle pulse after a reset port access |

## Verification
The assertions check four rules on every cycle. A wait is inserted only on a data port read during an active remote read. A fetched word is accepted only while a fetch is outstanding. The count falls by exactly two per step and done rises only with a zero count. A reset pulse always leaves the engine idle and not done. The bench scenarios cover what a single-cycle property cannot show: the PROM contents and their mirrors, RAM aliasing across the ignored address bits, and dropped PROM writes. They also cover the split between a waited back-to-back read and an unwaited spaced read, and the odd-count termination.

// File: rtl/ioport_pkg.sv
// Package: shared types and register offsets for the I/O window and DMA engine.
// Assumes byte-wide registers in the low half of a 32-byte window.
package ioport_pkg;

    typedef enum logic [1:0] {
        DM_IDLE  = 2'd0,
        DM_READ  = 2'd1,
        DM_WRITE = 2'd2
    } dma_mode_t;

    typedef struct packed {
        logic       reg_hit;
        logic       data_hit;
        logic       rst_hit;
        logic [3:0] reg_off;
    } io_dec_t;

    localparam logic [3:0] OFF_ADDR_LO = 4'h0;
    localparam logic [3:0] OFF_ADDR_HI = 4'h1;
    localparam logic [3:0] OFF_CNT_LO  = 4'h2;
    localparam logic [3:0] OFF_CNT_HI  = 4'h3;
    localparam logic [3:0] OFF_STATUS  = 4'h4;
    localparam logic [3:0] OFF_CMD     = 4'h5;

endpackage

// File: rtl/ioport_decode.sv
// Module: window decoder. Compares the upper address bits with the base and
// splits the 32-byte window into register, data port and reset port regions.
// Assumes the base is 32-byte aligned; low base bits are ignored.
module ioport_decode
    import ioport_pkg::*;
#(
    parameter int IO_AW = 10
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_AW-1:0] cfg_base,
    output io_dec_t          dec
);

    localparam int WIN_BITS = 5;

    logic win_hit;
    logic unused_base;

    // Window match on the bits above the 32-byte offset.
    always_comb begin
        win_hit       = (io_addr[IO_AW-1:WIN_BITS] == cfg_base[IO_AW-1:WIN_BITS]);
        dec.reg_hit   = win_hit && (io_addr[4] == 1'b0);
        dec.data_hit  = win_hit && (io_addr[4:3] == 2'b10);
        dec.rst_hit   = win_hit && (io_addr[4:3] == 2'b11);
        dec.reg_off   = io_addr[3:0];
    end

    assign unused_base = ^cfg_base[WIN_BITS-1:0];

endmodule

// File: rtl/rdma_memory.sv
// Module: internal memory space behind the remote DMA port. Bit 14 of the byte
// address picks PROM or RAM; bit 15 is ignored. Reads return after RD_LAT
// cycles through a flushable pipeline; writes land in one cycle, RAM only.
// Assumes at most one read request per cycle and RD_LAT >= 1.
module rdma_memory #(
    parameter int          RAM_AW   = 11,
    parameter int          RD_LAT   = 3,
    parameter logic [47:0] MAC_ADDR = 48'h665544332211
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        rd_req,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    output logic        rd_valid,
    output logic [15:0] rd_data
);

    localparam int RAM_WORDS = 1 << RAM_AW;

    logic [15:0] ram [RAM_WORDS];
    logic [12:0] widx;
    logic [15:0] rd_word;
    logic [RD_LAT-1:0] vld_q;
    logic [15:0] dat_q [RD_LAT];
    logic unused_addr;

    // PROM contents: station address bytes, signature words, zeros elsewhere.
    function automatic logic [15:0] prom_word(input logic [3:0] idx);
        if (idx < 4'd6)
            return {8'h00, MAC_ADDR[8*idx +: 8]};
        else if (idx >= 4'd14)
            return 16'h0057;
        else
            return 16'h0000;
    endfunction

    assign widx = addr[13:1];

    // Combinational word select from the partially decoded space.
    always_comb begin
        if (addr[14])
            rd_word = ram[widx[RAM_AW-1:0]];
        else
            rd_word = prom_word(addr[4:1]);
    end

    // RAM write port; PROM region writes are dropped.
    always_ff @(posedge clk) begin
        if (wr_en && addr[14])
            ram[widx[RAM_AW-1:0]] <= wdata;
    end

    // Valid bits of the read latency pipeline, cleared on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= rd_req && !flush;
            for (int k = 1; k < RD_LAT; k++)
                vld_q[k] <= vld_q[k-1] && !flush;
        end
    end

    // Data stages of the read latency pipeline.
    always_ff @(posedge clk) begin
        dat_q[0] <= rd_word;
        for (int k = 1; k < RD_LAT; k++)
            dat_q[k] <= dat_q[k-1];
    end

    assign rd_valid    = vld_q[RD_LAT-1];
    assign rd_data     = dat_q[RD_LAT-1];
    assign unused_addr = ^{addr[15], addr[0], widx};

endmodule

// File: rtl/rdma_engine.sv
// Module: register bank and remote DMA sequencer. Holds the start address,
// byte count and done flag, runs read or write transfers through the data
// port, prefetches one word ahead on reads and drives channel-ready.
// Assumes the host holds io_rd until chrdy is high and pulses io_wr once.
module rdma_engine
    import ioport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  io_dec_t     dec,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [15:0] io_wdata,
    input  logic        mem_rd_valid,
    input  logic [15:0] mem_rd_data,
    output logic        mem_rd_req,
    output logic        mem_wr_en,
    output logic        mem_flush,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic [7:0]  reg_rdata,
    output logic [15:0] port_rdata,
    output logic        chrdy,
    output logic        soft_reset,
    output logic        dma_done,
    output logic        dma_rd_active,
    output logic        dma_step,
    output logic        dma_pend,
    output logic [15:0] dma_cnt
);

    dma_mode_t   mode_q;
    logic [15:0] addr_q;
    logic [15:0] cnt_q;
    logic        done_q;
    logic        buf_full_q;
    logic [15:0] buf_q;
    logic        fetch_q;
    logic        pend_q;
    logic        srst_q;

    logic rd_step, wr_step, last, rst_acc, cmd_wr, start_rd, start_wr, reg_wr;

    // Access classification for the current cycle.
    always_comb begin
        rd_step  = io_rd && dec.data_hit && (mode_q == DM_READ) && buf_full_q;
        wr_step  = io_wr && dec.data_hit && (mode_q == DM_WRITE);
        last     = (cnt_q <= 16'd2);
        rst_acc  = (io_rd || io_wr) && dec.rst_hit;
        reg_wr   = io_wr && dec.reg_hit;
        cmd_wr   = reg_wr && (dec.reg_off == OFF_CMD);
        start_rd = cmd_wr && io_wdata[0];
        start_wr = cmd_wr && io_wdata[1] && !io_wdata[0];
    end

    // Sequencer state: register writes, starts, steps, fills and aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= DM_IDLE;
            addr_q     <= '0;
            cnt_q      <= '0;
            done_q     <= 1'b0;
            buf_full_q <= 1'b0;
            buf_q      <= '0;
            fetch_q    <= 1'b0;
            pend_q     <= 1'b0;
            srst_q     <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            srst_q  <= rst_acc;
            if (rst_acc) begin
                mode_q     <= DM_IDLE;
                done_q     <= 1'b0;
                buf_full_q <= 1'b0;
                pend_q     <= 1'b0;
            end else if (start_rd || start_wr) begin
                done_q     <= 1'b0;
                buf_full_q <= 1'b0;
                pend_q     <= 1'b0;
                if (cnt_q == 16'd0) begin
                    done_q <= 1'b1;
                    mode_q <= DM_IDLE;
                end else if (start_rd) begin
                    mode_q  <= DM_READ;
                    fetch_q <= 1'b1;
                    pend_q  <= 1'b1;
                end else begin
                    mode_q <= DM_WRITE;
                end
            end else begin
                if (reg_wr) begin
                    case (dec.reg_off)
                        OFF_ADDR_LO: addr_q[7:0]  <= io_wdata[7:0];
                        OFF_ADDR_HI: addr_q[15:8] <= io_wdata[7:0];
                        OFF_CNT_LO:  cnt_q[7:0]   <= io_wdata[7:0];
                        OFF_CNT_HI:  cnt_q[15:8]  <= io_wdata[7:0];
                        default: ;
                    endcase
                end
                if (mem_rd_valid && pend_q) begin
                    buf_q      <= mem_rd_data;
                    buf_full_q <= 1'b1;
                    pend_q     <= 1'b0;
                end
                if (rd_step || wr_step) begin
                    addr_q     <= addr_q + 16'd2;
                    cnt_q      <= last ? 16'd0 : cnt_q - 16'd2;
                    buf_full_q <= 1'b0;
                    if (last) begin
                        done_q <= 1'b1;
                        mode_q <= DM_IDLE;
                    end else if (rd_step) begin
                        fetch_q <= 1'b1;
                        pend_q  <= 1'b1;
                    end
                end
            end
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (dec.reg_off)
            OFF_ADDR_LO: reg_rdata = addr_q[7:0];
            OFF_ADDR_HI: reg_rdata = addr_q[15:8];
            OFF_CNT_LO:  reg_rdata = cnt_q[7:0];
            OFF_CNT_HI:  reg_rdata = cnt_q[15:8];
            OFF_STATUS:  reg_rdata = {7'd0, done_q};
            OFF_CMD:     reg_rdata = {6'd0, mode_q == DM_WRITE, mode_q == DM_READ};
            default:     reg_rdata = 8'h00;
        endcase
    end

    // Data port output and wait-state generation.
    always_comb begin
        port_rdata = ((mode_q == DM_READ) && buf_full_q) ? buf_q : 16'h0000;
        chrdy      = !(io_rd && dec.data_hit && (mode_q == DM_READ) && !buf_full_q);
    end

    assign mem_rd_req    = fetch_q;
    assign mem_wr_en     = wr_step;
    assign mem_flush     = rst_acc || start_rd || start_wr;
    assign mem_addr      = addr_q;
    assign mem_wdata     = io_wdata;
    assign soft_reset    = srst_q;
    assign dma_done      = done_q;
    assign dma_rd_active = (mode_q == DM_READ);
    assign dma_step      = rd_step || wr_step;
    assign dma_pend      = pend_q;
    assign dma_cnt       = cnt_q;

endmodule

// File: rtl/ioport_rdma.sv
// Module: top of the I/O window with remote DMA. Joins the decoder, the DMA
// engine and the memory space, and muxes read data onto the bus.
// Assumes a single host bus master and a synchronous bus clock.
module ioport_rdma
    import ioport_pkg::*;
#(
    parameter int          IO_AW    = 10,
    parameter int          RAM_AW   = 11,
    parameter int          RD_LAT   = 3,
    parameter logic [47:0] MAC_ADDR = 48'h665544332211
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] cfg_base,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [15:0]      io_wdata,
    output logic [15:0]      io_rdata,
    output logic             chrdy,
    output logic             soft_reset
);

    io_dec_t     dec;
    logic        mem_rd_req, mem_wr_en, mem_flush, mem_rd_valid;
    logic [15:0] mem_addr, mem_wdata, mem_rd_data, port_rdata;
    logic [7:0]  reg_rdata;
    logic        dma_done, dma_rd_active, dma_step, dma_pend;
    logic [15:0] dma_cnt;

    ioport_decode #(.IO_AW(IO_AW)) u_dec (
        .io_addr (io_addr),
        .cfg_base(cfg_base),
        .dec     (dec)
    );

    rdma_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec          (dec),
        .io_rd        (io_rd),
        .io_wr        (io_wr),
        .io_wdata     (io_wdata),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_rd_req   (mem_rd_req),
        .mem_wr_en    (mem_wr_en),
        .mem_flush    (mem_flush),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .reg_rdata    (reg_rdata),
        .port_rdata   (port_rdata),
        .chrdy        (chrdy),
        .soft_reset   (soft_reset),
        .dma_done     (dma_done),
        .dma_rd_active(dma_rd_active),
        .dma_step     (dma_step),
        .dma_pend     (dma_pend),
        .dma_cnt      (dma_cnt)
    );

    rdma_memory #(.RAM_AW(RAM_AW), .RD_LAT(RD_LAT), .MAC_ADDR(MAC_ADDR)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (mem_flush),
        .rd_req  (mem_rd_req),
        .wr_en   (mem_wr_en),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .rd_valid(mem_rd_valid),
        .rd_data (mem_rd_data)
    );

    // Bus read data: register byte, data port word, or zero.
    always_comb begin
        if (io_rd && dec.reg_hit)
            io_rdata = {8'h00, reg_rdata};
        else if (io_rd && dec.data_hit)
            io_rdata = port_rdata;
        else
            io_rdata = 16'h0000;
    end

endmodule

// File: rtl/ioport_rdma_chk.sv
// Module: property checker for ioport_rdma, attached with bind below.
// Assumes the top's internal DMA status nets keep their names.
module ioport_rdma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_rd,
    input logic        chrdy,
    input logic        data_hit,
    input logic        soft_reset,
    input logic        dma_done,
    input logic        dma_rd_active,
    input logic        dma_step,
    input logic        dma_pend,
    input logic        mem_rd_valid,
    input logic [15:0] dma_cnt
);

    // R8: a wait is only ever inserted on a data port read during a remote read.
    a_r8_wait_only_on_port_read: assert property (@(posedge clk) disable iff (!rst_n)
        !chrdy |-> (io_rd && data_hit && dma_rd_active));

    // R8: a returning memory word is only accepted while a fetch is outstanding.
    a_r8_fill_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> dma_pend);

    // R6: a step with more than two bytes left lowers the count by exactly two.
    a_r6_count_minus_two: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_step && dma_cnt > 16'd2) |=> (dma_cnt == $past(dma_cnt) - 16'd2));

    // R7: done only rises with the count at zero.
    a_r7_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_done) |-> (dma_cnt == 16'd0));

    // R10: a reset pulse leaves the engine idle and not done.
    a_r10_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> (!dma_rd_active && !dma_done));

    // R11: with no remote read active the bus is never held.
    a_r11_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_rd_active |-> chrdy);

endmodule

bind ioport_rdma ioport_rdma_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_rd        (io_rd),
    .chrdy        (chrdy),
    .data_hit     (dec.data_hit),
    .soft_reset   (soft_reset),
    .dma_done     (dma_done),
    .dma_rd_active(dma_rd_active),
    .dma_step     (dma_step),
    .dma_pend     (dma_pend),
    .mem_rd_valid (mem_rd_valid),
    .dma_cnt      (dma_cnt)
);

// File: tb/ioport_rdma_test.sv
// Bench for ioport_rdma: a vector table of single-word remote reads, then
// directed tests for reset state, decode, waits, odd counts and reset port.
module ioport_rdma_test;

    localparam int          IO_AW = 10;
    localparam logic [9:0]  BASE  = 10'h300;
    localparam logic [9:0]  PDATA = BASE + 10'h10;
    localparam logic [9:0]  PRST  = BASE + 10'h18;
    localparam int          NVEC  = 17;
    // {memory byte address, expected word}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 16'h0011}, {16'h0002, 16'h0022}, {16'h0004, 16'h0033},
        {16'h0006, 16'h0044}, {16'h0008, 16'h0055}, {16'h000A, 16'h0066},
        {16'h000C, 16'h0000}, {16'h001C, 16'h0057}, {16'h001E, 16'h0057},
        {16'h0022, 16'h0022}, {16'h3FFC, 16'h0057}, {16'h8004, 16'h0033},
        {16'h4000, 16'h1234}, {16'h4006, 16'hDEF0}, {16'hC002, 16'h5678},
        {16'h5004, 16'h9ABC}, {16'h7000, 16'h1234}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IO_AW-1:0] io_addr = '0;
    logic             io_rd = 1'b0;
    logic             io_wr = 1'b0;
    logic [15:0]      io_wdata = '0;
    logic [15:0]      io_rdata;
    logic             chrdy;
    logic             soft_reset;

    int n_chk = 0;
    int n_bad = 0;
    int n_pulse = 0;
    bit finished = 1'b0;

    ioport_rdma uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .chrdy(chrdy), .soft_reset(soft_reset)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (soft_reset) n_pulse++;

    task automatic chk(input string rq, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", rq, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [15:0] d, output int waits);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0; waits = 0;
        #1;
        while (!chrdy && waits < 1000) begin
            @(negedge clk); #1;
            waits++;
        end
        d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic set_dma(input logic [15:0] a, input logic [15:0] c);
        bus_wr(BASE + 10'h0, {8'h00, a[7:0]});
        bus_wr(BASE + 10'h1, {8'h00, a[15:8]});
        bus_wr(BASE + 10'h2, {8'h00, c[7:0]});
        bus_wr(BASE + 10'h3, {8'h00, c[15:8]});
    endtask

    task automatic rd_reg16(input logic [9:0] lo, output logic [15:0] v);
        logic [15:0] a, b;
        int w;
        bus_rd(lo, a, w);
        bus_rd(lo + 10'h1, b, w);
        v = {b[7:0], a[7:0]};
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, v;
        int w, p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 reset chrdy high", {15'd0, chrdy}, 16'h0001);
        bus_rd(BASE + 10'h4, d, w);  chk("R7 reset done clear", d, 16'h0000);
        rd_reg16(BASE + 10'h2, v);   chk("R2 reset count zero", v, 16'h0000);
        rd_reg16(BASE + 10'h0, v);   chk("R2 reset address zero", v, 16'h0000);

        // R1: wrong base is ignored and reads zero.
        set_dma(16'h1234, 16'h0004);
        bus_wr(10'h202, 16'h0099);
        rd_reg16(BASE + 10'h2, v);   chk("R1 foreign write ignored", v, 16'h0004);
        bus_rd(10'h200, d, w);       chk("R1 foreign read zero", d, 16'h0000);
        bus_rd(BASE + 10'h7, d, w);  chk("R2 unused offset reads zero", d, 16'h0000);
        rd_reg16(BASE + 10'h0, v);   chk("R2 address readback", v, 16'h1234);

        // R11: data port read with no read DMA.
        bus_rd(PDATA, d, w);
        chk("R11 idle port data", d, 16'h0000);
        chk("R11 idle port no wait", w[15:0], 16'h0000);
        rd_reg16(BASE + 10'h0, v);   chk("R11 idle port address kept", v, 16'h1234);

        // R7: zero count start finishes at once.
        set_dma(16'h4000, 16'h0000);
        bus_wr(BASE + 10'h5, 16'h0001);
        bus_rd(BASE + 10'h4, d, w);  chk("R7 zero count done", d, 16'h0001);

        // R5/R6: write four RAM words.
        set_dma(16'h4000, 16'h0008);
        bus_wr(BASE + 10'h5, 16'h0002);
        bus_rd(BASE + 10'h4, d, w);  chk("R7 start clears done", d, 16'h0000);
        bus_rd(BASE + 10'h5, d, w);  chk("R2 write active bit", d, 16'h0002);
        bus_wr(PDATA, 16'h1234);
        bus_wr(PDATA + 10'h1, 16'h5678);
        bus_wr(PDATA + 10'h7, 16'h9ABC);
        bus_wr(PDATA, 16'hDEF0);
        rd_reg16(BASE + 10'h2, v);   chk("R6 write count zero", v, 16'h0000);
        rd_reg16(BASE + 10'h0, v);   chk("R6 write address advanced", v, 16'h4008);
        bus_rd(BASE + 10'h4, d, w);  chk("R7 write done", d, 16'h0001);

        // R9: write into the PROM region is dropped (checked by the table, word 0).
        set_dma(16'h0000, 16'h0002);
        bus_wr(BASE + 10'h5, 16'h0002);
        bus_wr(PDATA, 16'hFFFF);
        bus_rd(BASE + 10'h4, d, w);  chk("R9 prom write step done", d, 16'h0001);

        // Table: one-word remote reads (R3 R4 R5 R9).
        for (int i = 0; i < NVEC; i++) begin
            set_dma(VEC[i][31:16], 16'h0002);
            bus_wr(BASE + 10'h5, 16'h0001);
            idle(8);
            bus_rd(PDATA, d, w);
            chk($sformatf("R3 R4 R5 R9 word at %h", VEC[i][31:16]), d, VEC[i][15:0]);
            rd_reg16(BASE + 10'h0, v);
            chk("R6 read address advanced", v, VEC[i][31:16] + 16'd2);
            bus_rd(BASE + 10'h4, d, w);
            chk("R7 read done", d, 16'h0001);
        end

        // R8: spaced reads do not wait; back-to-back reads do.
        set_dma(16'h4000, 16'h0006);
        bus_wr(BASE + 10'h5, 16'h0001);
        idle(10);
        bus_rd(PDATA, d, w);
        chk("R8 first word", d, 16'h1234);
        chk("R8 spaced read no wait", w[15:0], 16'h0000);
        bus_rd(PDATA, d, w);
        chk("R8 back-to-back word", d, 16'h5678);
        chk("R8 back-to-back waits", {15'd0, w > 0}, 16'h0001);
        idle(10);
        bus_rd(PDATA + 10'h6, d, w);
        chk("R8 third word", d, 16'h9ABC);
        chk("R8 third no wait", w[15:0], 16'h0000);
        bus_rd(BASE + 10'h4, d, w);  chk("R7 three word done", d, 16'h0001);

        // R6: odd count ends after the count goes below two.
        set_dma(16'h4000, 16'h0003);
        bus_wr(BASE + 10'h5, 16'h0001);
        bus_rd(PDATA, d, w);
        rd_reg16(BASE + 10'h2, v);   chk("R6 odd count after one", v, 16'h0001);
        bus_rd(BASE + 10'h4, d, w);  chk("R6 odd not done yet", d, 16'h0000);
        bus_rd(PDATA, d, w);         chk("R6 odd second word", d, 16'h5678);
        rd_reg16(BASE + 10'h2, v);   chk("R6 odd count zero", v, 16'h0000);

        // R10: reset port aborts a read.
        set_dma(16'h4000, 16'h0004);
        bus_wr(BASE + 10'h5, 16'h0001);
        idle(6);
        p0 = n_pulse;
        bus_rd(PRST, d, w);
        idle(2);
        chk("R10 one pulse on read", n_pulse[15:0] - p0[15:0], 16'h0001);
        bus_rd(BASE + 10'h5, d, w);  chk("R10 engine idle", d, 16'h0000);
        bus_rd(BASE + 10'h4, d, w);  chk("R10 done clear", d, 16'h0000);
        rd_reg16(BASE + 10'h2, v);   chk("R10 count kept", v, 16'h0004);
        bus_rd(PDATA, d, w);
        chk("R11 after abort no wait", w[15:0], 16'h0000);
        chk("R11 after abort data zero", d, 16'h0000);
        p0 = n_pulse;
        bus_wr(PRST + 10'h7, 16'h0000);
        idle(2);
        chk("R10 one pulse on write", n_pulse[15:0] - p0[15:0], 16'h0001);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule